// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits in the column path of a synchronous DRAM controller or device model. A read or write command loads a start column together with the burst settings from the mode register. The block then produces one column address per beat until the burst runs out, a burst-stop request arrives, or a new command replaces it. The settings are a 3-bit length code, a 1-bit burst type and a single-write flag. The current column is accompanied by a beat-valid flag and a last-beat flag.

Beats leave the block as a stream. `beat_vld_o` is the valid and `adv_i` acts as the ready. A beat is consumed only in a cycle where both are high, and while `adv_i` is low the block holds the same beat with all outputs unchanged. This is the only back-pressure. A new command on `load_i` is always accepted and never waits for the current burst to drain.

Sequential bursts count upward inside an aligned block of the burst length, and the upper column bits stay fixed. Interleaved bursts XOR the beat index into the low bits of the start column. A full-page burst walks all 256 columns with wrap-around and never flags a last beat on its own. Mode combinations that have no meaning are reported on a combinational flag and run as single-beat bursts.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `beat_vld_o`, `last_o` and `col_o` are all 0.
- R2: In the cycle after `load_i` is high at a rising edge, `beat_vld_o` is 1 and `col_o` equals the loaded start column. This first beat has beat index 0.
- R3: The length code on `mode_bl_i` selects the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. `mode_bt_i` is 0 for sequential and 1 for interleaved. The settings take effect at the load edge.
- R4: For a sequential burst of length L in {2,4,8}, beat k has column `(start & ~(L-1)) | ((start + k) & (L-1))`.
- R5: For an interleaved burst of length L in {4,8}, beat k has column `start ^ k`.
- R6: `mode_illegal_o` is 1 exactly when one of these holds: an interleaved burst has any code other than 010 or 011, or a sequential burst has code 100, 101 or 110. Such a burst runs as length 1.
- R7: A full-page burst gives column `(start + k) mod 256` on beat k and never raises `last_o`. It ends only through `stop_i` or a new load.
- R8: If `mode_single_wr_i` and `load_is_write_i` are both 1 at the load, the burst is one beat long whatever the length code. Read loads are not affected.
- R9: `last_o` is 1 on the final beat of a fixed-length burst. If that beat is advanced, `beat_vld_o` is 0 in the next cycle.
- R10: While a burst is active and `adv_i`, `stop_i` and `load_i` are all 0, `col_o`, `last_o` and `beat_vld_o` hold their values.
- R11: `stop_i` high during an active burst, without `load_i`, makes `beat_vld_o` 0 in the next cycle, even if `adv_i` is also high.
- R12: `load_i` takes priority over `stop_i` and `adv_i`. A load during a burst restarts at beat 0 with the new start column and settings.
- R13: Changes to the mode inputs after the load have no effect on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | New read/write command: start a burst |
| load_is_write_i | input | 1 | 1 if the loaded command is a write |
| load_col_i | input | COL_W | Start column of the burst |
| adv_i | input | 1 | Consume the current beat (ready) |
| stop_i | input | 1 | Burst-stop request |
| mode_bl_i | input | 3 | Burst length code |
| mode_bt_i | input | 1 | Burst type: 0 sequential, 1 interleaved |
| mode_single_wr_i | input | 1 | Single-beat writes, reads still burst |
| col_o | output | COL_W | Column address of the current beat, 0 when idle |
| beat_vld_o | output | 1 | A beat is presented (valid) |
| last_o | output | 1 | Current beat is the final one |
| mode_illegal_o | output | 1 | Current mode inputs form an illegal combination |

## Verification
Directed bursts place start columns in the middle of an aligned block, so that a design which increments the whole address, or which adds where it should XOR, gives a different column. One full-page burst starts at 250 to show the wrap past 255 and the absence of a last flag. Single-write is applied to both a write load and a read load with the same length code, which separates the two command kinds. Stop, hold and reload are each applied in the middle of a burst and combined with `adv_i`, which checks their priority order. A long seeded random stream then mixes all eight length codes, both types, random back-pressure, stops, reloads and mode changes in mid-burst. It is compared every cycle against a cycle model kept in the bench.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int BL_CODE_W = 3;
  localparam logic [BL_CODE_W-1:0] BL_ONE  = 3'b000;
  localparam logic [BL_CODE_W-1:0] BL_TWO  = 3'b001;
  localparam logic [BL_CODE_W-1:0] BL_FOUR = 3'b010;
  localparam logic [BL_CODE_W-1:0] BL_EGT  = 3'b011;
  localparam logic [BL_CODE_W-1:0] BL_PAGE = 3'b111;

  // Decoded burst shape: log2 of fixed length, full-page and interleave flags
  typedef struct packed {
    logic       full;
    logic       ilv;
    logic [1:0] lg;
  } burst_cfg_t;
endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import colgen_pkg::*;
(
  input  logic [BL_CODE_W-1:0] bl_i,
  input  logic                 bt_i,
  input  logic                 wr_i,
  input  logic                 single_wr_i,
  output burst_cfg_t           cfg_o,
  output logic                 illegal_o
);
  always_comb begin
    cfg_o      = '0;
    cfg_o.ilv  = bt_i;
    if (bt_i) illegal_o = (bl_i != BL_FOUR) && (bl_i != BL_EGT);
    else      illegal_o = (bl_i[2] && (bl_i != BL_PAGE));
    unique case (bl_i)
      BL_TWO:  cfg_o.lg = bt_i ? 2'd0 : 2'd1;
      BL_FOUR: cfg_o.lg = 2'd2;
      BL_EGT:  cfg_o.lg = 2'd3;
      BL_PAGE: cfg_o.full = !bt_i;
      default: cfg_o.lg = 2'd0;
    endcase
    // single-beat writes override any programmed length
    if (wr_i && single_wr_i) begin
      cfg_o.lg   = 2'd0;
      cfg_o.full = 1'b0;
    end
  end
endmodule

// File: rtl/colgen_beat_ctl.sv
module colgen_beat_ctl
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_i,
  input  burst_cfg_t       cfg_i,
  output logic             active_o,
  output logic [COL_W-1:0] start_o,
  output logic [COL_W-1:0] cnt_o,
  output burst_cfg_t       cfg_o,
  output logic             last_o
);
  logic [COL_W-1:0] blk_mask;

  assign blk_mask = ~({COL_W{1'b1}} << cfg_o.lg);
  assign last_o   = active_o && !cfg_o.full && (cnt_o == blk_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      start_o  <= '0;
      cnt_o    <= '0;
      cfg_o    <= '0;
    end else if (load_i) begin
      active_o <= 1'b1;
      start_o  <= start_i;
      cnt_o    <= '0;
      cfg_o    <= cfg_i;
    end else if (active_o) begin
      if (stop_i)      active_o <= 1'b0;
      else if (adv_i) begin
        if (last_o)    active_o <= 1'b0;
        else           cnt_o    <= cnt_o + 1'b1;
      end
    end
  end

  assert_load_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (active_o && cnt_o == '0 && start_o == $past(start_i)));
  assert_last_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && adv_i && !stop_i && !load_i) |=> !active_o);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !adv_i && !stop_i && !load_i) |=> (active_o && $stable(cnt_o)));
  assert_stop_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && stop_i && !load_i) |=> !active_o);
  assert_page_no_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && cfg_o.full) |-> !last_o);
  assert_mode_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !load_i) |=> $stable(cfg_o));
endmodule

// File: rtl/colgen_addr_gen.sv
module colgen_addr_gen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] cnt_i,
  input  burst_cfg_t       cfg_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] raw;

  assign sum = start_i + cnt_i;

  // Bits inside the burst block follow the burst order, the rest keep the start
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    logic in_blk;
    assign in_blk = cfg_i.full || (int'(cfg_i.lg) > i);
    assign raw[i] = !in_blk   ? start_i[i] :
                    cfg_i.ilv ? (start_i[i] ^ cnt_i[i]) : sum[i];
  end

  assign col_o = active_i ? raw : '0;

  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !cfg_i.full) |->
      (((col_o ^ start_i) & ({COL_W{1'b1}} << cfg_i.lg)) == '0));
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |-> (col_o == '0));
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             load_is_write_i,
  input  logic [COL_W-1:0] load_col_i,
  input  logic             adv_i,
  input  logic             stop_i,
  input  logic [2:0]       mode_bl_i,
  input  logic             mode_bt_i,
  input  logic             mode_single_wr_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             last_o,
  output logic             mode_illegal_o
);
  burst_cfg_t       new_cfg;
  burst_cfg_t       cur_cfg;
  logic [COL_W-1:0] cur_start;
  logic [COL_W-1:0] cur_cnt;
  logic             active;

  colgen_mode_dec u_dec (
    .bl_i        (mode_bl_i),
    .bt_i        (mode_bt_i),
    .wr_i        (load_is_write_i),
    .single_wr_i (mode_single_wr_i),
    .cfg_o       (new_cfg),
    .illegal_o   (mode_illegal_o)
  );

  colgen_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .adv_i    (adv_i),
    .stop_i   (stop_i),
    .start_i  (load_col_i),
    .cfg_i    (new_cfg),
    .active_o (active),
    .start_o  (cur_start),
    .cnt_o    (cur_cnt),
    .cfg_o    (cur_cfg),
    .last_o   (last_o)
  );

  colgen_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .start_i  (cur_start),
    .cnt_i    (cur_cnt),
    .cfg_i    (cur_cfg),
    .col_o    (col_o)
  );

  assign beat_vld_o = active;

  assert_illegal_one_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && mode_illegal_o) |=> last_o);
  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_is_write_i && mode_single_wr_i) |=> (beat_vld_o && last_o));
  assert_reload_R12: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_vld_o && col_o == $past(load_col_i)));
endmodule

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;
  localparam int COL_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, load, is_wr, adv, stop, bt, sw;
  logic [COL_W-1:0] start;
  logic [2:0]       bl;
  logic [COL_W-1:0] col;
  logic             vld, last, illegal;

  sdram_burst_colgen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_is_write_i(is_wr),
    .load_col_i(start), .adv_i(adv), .stop_i(stop), .mode_bl_i(bl),
    .mode_bt_i(bt), .mode_single_wr_i(sw), .col_o(col), .beat_vld_o(vld),
    .last_o(last), .mode_illegal_o(illegal)
  );

  int n_chk = 0, n_bad = 0;
  // bench model of the burst (len 0 means full page)
  int m_act = 0, m_start = 0, m_k = 0, m_len = 1, m_ilv = 0;

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int exp_len(int c, int t, int w, int s);
    if (w != 0 && s != 0) return 1;
    if (t != 0) return (c == 2) ? 4 : (c == 3) ? 8 : 1;
    case (c)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_ill(int c, int t);
    if (t != 0) return (c != 2 && c != 3) ? 1 : 0;
    return (c >= 4 && c <= 6) ? 1 : 0;
  endfunction

  function automatic int exp_col();
    if (m_act == 0) return 0;
    if (m_len == 0) return (m_start + m_k) % 256;
    if (m_ilv != 0) return m_start ^ m_k;
    return (m_start & ~(m_len - 1)) | ((m_start + m_k) & (m_len - 1));
  endfunction

  function automatic string col_tag();
    if (m_len == 0) return "R7 full-page col";
    if (m_ilv != 0 && m_len > 1) return "R5 interleave col";
    return "R4 sequential col";
  endfunction

  task automatic step(int ld, int w, int sc, int ad, int st, int c, int t, int s, string tag);
    int e_last;
    load = 1'(ld); is_wr = 1'(w); start = COL_W'(sc); adv = 1'(ad);
    stop = 1'(st); bl = 3'(c); bt = 1'(t); sw = 1'(s);
    #1;
    chk({"R6 illegal flag ", tag}, int'(illegal), exp_ill(c, t));
    @(posedge clk);
    e_last = (m_act != 0 && m_len != 0 && m_k == m_len - 1) ? 1 : 0;
    if (ld != 0) begin
      m_act = 1; m_start = sc; m_k = 0; m_len = exp_len(c, t, w, s); m_ilv = t;
    end else if (m_act != 0 && st != 0) begin
      m_act = 0;
    end else if (m_act != 0 && ad != 0) begin
      if (e_last != 0) m_act = 0;
      else m_k = (m_k + 1) % 256;
    end
    @(negedge clk);
    e_last = (m_act != 0 && m_len != 0 && m_k == m_len - 1) ? 1 : 0;
    chk({"R2 beat valid ", tag}, int'(vld), m_act);
    chk({"R9 last flag ", tag}, int'(last), e_last);
    chk({col_tag(), " ", tag}, int'(col), exp_col());
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed1);
    rst_n = 0; load = 0; is_wr = 0; start = 0; adv = 0; stop = 0;
    bl = 0; bt = 0; sw = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", int'(vld), 0);
    chk("R1 reset last", int'(last), 0);
    chk("R1 reset col", int'(col), 0);
    rst_n = 1;
    step(0, 0, 0, 1, 0, 0, 0, 0, "R1 idle after reset");
    // R3 R4: length 4 sequential from mid-block column 0x0E
    step(1, 0, 8'h0E, 0, 0, 2, 0, 0, "R3 load len4");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 2, 0, 0, "R4 seq4 walk");
    // R5: interleaved length 8 from 0x35
    step(1, 0, 8'h35, 0, 0, 3, 1, 0, "R5 load ilv8");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 0, 3, 1, 0, "R5 ilv8 walk");
    // R7: full page across the 255 -> 0 wrap
    step(1, 0, 250, 1, 0, 7, 0, 0, "R7 load page");
    for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 0, 7, 0, 0, "R7 page wrap");
    step(0, 0, 0, 1, 1, 7, 0, 0, "R7 R11 stop page");
    // R8: single write vs read with the same code
    step(1, 1, 8'h40, 0, 0, 3, 0, 1, "R8 single write");
    step(0, 0, 0, 1, 0, 3, 0, 1, "R8 write retires");
    step(1, 0, 8'h40, 1, 0, 3, 0, 1, "R8 read bursts");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 0, 3, 0, 1, "R8 read walk");
    // R10 hold, R13 mode change mid-burst, R11 stop over adv
    step(1, 0, 8'h13, 0, 0, 3, 0, 0, "R10 load");
    step(0, 0, 0, 1, 0, 0, 1, 1, "R13 mode change");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 7, 1, 0, "R10 hold");
    step(0, 0, 0, 1, 0, 1, 0, 0, "R13 continue");
    step(0, 0, 0, 1, 1, 3, 0, 0, "R11 stop beats adv");
    // R12: reload mid-burst with stop and adv also high
    step(1, 0, 8'h21, 0, 0, 2, 1, 0, "R12 first");
    step(0, 0, 0, 1, 0, 2, 1, 0, "R12 advance");
    step(1, 0, 8'h9C, 1, 1, 1, 0, 0, "R12 reload");
    for (int i = 0; i < 2; i++) step(0, 0, 0, 1, 0, 1, 0, 0, "R12 len2 walk");
    // R6: illegal combinations run one beat
    step(1, 0, 8'h77, 0, 0, 7, 1, 0, "R6 ilv page");
    step(0, 0, 0, 1, 0, 5, 0, 0, "R6 seq code5");
    step(1, 0, 8'h78, 0, 0, 5, 0, 0, "R6 load code5");
    step(0, 0, 0, 1, 0, 1, 1, 0, "R6 ilv code1");
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r_ld, r_ad, r_st;
      r_ld = ($urandom % 8 == 0) ? 1 : 0;
      r_ad = ($urandom % 4 != 0) ? 1 : 0;
      r_st = ($urandom % 20 == 0) ? 1 : 0;
      step(r_ld, int'($urandom % 2), int'($urandom % 256), r_ad, r_st,
           int'($urandom % 8), int'($urandom % 2), int'($urandom % 2), "R13 random");
    end
    summary();
    $finish;
  end
endmodule